// File: doc/BRIEF.md
# Interrupt Priority Register Bank

This block holds one 8-bit priority for every shared interrupt and exposes it through a simple register port. A request can be byte-sized or word-sized. A byte request reaches a single priority. A word request reaches four consecutive priorities. Every request carries a secure attribute. The block drives the complete priority array on a flat output vector, which a downstream arbiter samples; the arbiter itself is outside this block.

Security filtering applies per interrupt. A per-interrupt group vector and a global security-off input decide what a request may see. Secure requests use raw values, and so does every request while security is off. Non-secure requests cannot see group-0 interrupts at all. For group-1 interrupts they use a halved-range view: a read returns the value shifted up one bit, and a write stores the value shifted down one bit with the top bit forced high. Interrupt numbers below 32, and those at or above the implemented count, hold no storage.

Top module: `irq_prio_bank`

## Requirements
- R1: After reset every priority is 0x00, on the output array and on readback.
- R2: A word request covers interrupts base..base+3, where base is the address with its two low bits cleared. Interrupt base sits in bits 7:0 and base+3 in bits 31:24.
- R3: A byte request addresses one interrupt. It writes from bits 7:0 of the write data and ignores the upper bits. It returns the priority in bits 7:0 of the read data, with bits 31:8 at zero.
- R4: Secure requests, and all requests while `secOff` is 1, read and write the raw 8-bit priority.
- R5: A non-secure request with `secOff` at 0, to an interrupt whose group bit is 0, reads as 0x00 and leaves the priority unchanged.
- R6: A non-secure read of a group-1 interrupt returns the stored priority shifted left by one, truncated to 8 bits.
- R7: A non-secure write to a group-1 interrupt stores 0x80 OR (write byte >> 1).
- R8: Interrupt numbers below 32, or at or above NUM_IRQ, read as 0x00 and ignore writes.
- R9: A word write whose interrupt base+3 is at or above NUM_IRQ changes nothing. A word read returns 0x00 in each lane whose interrupt is not implemented.
- R10: A word write applies the group and security check to each of its four lanes on its own.
- R11: Read data and `rdValid` appear on the cycle after the request, and `rdValid` is high for that single cycle. A write shows on `prioArray` on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| regValid | input | 1 | Request strobe, one cycle per request |
| regWrite | input | 1 | 1 for a write, 0 for a read |
| regWide | input | 1 | 1 for a word (four-priority) request, 0 for a byte request |
| regAddr | input | ADDR_W | Byte address inside the priority space; it equals the interrupt number |
| regWdata | input | 32 | Write data |
| regSecure | input | 1 | Secure attribute of the request |
| irqGroup | input | NUM_IRQ | Group bit per interrupt (1 = group 1) |
| secOff | input | 1 | Security disabled: every request uses raw values |
| rdData | output | 32 | Read data, registered |
| rdValid | output | 1 | Read data valid pulse |
| prioArray | output | NUM_IRQ*8 | Priority of interrupt n in bits 8n+7:8n |

## Verification
The properties assume that `regAddr` and `irqGroup` are steady while `regValid` is high. They also assume that a write's effect is judged one cycle later with no other write in between. The group check in the properties indexes `irqGroup` by the request address, so those properties hold only while the group vector stays fixed across the request. The bench keeps to these assumptions. It ties `irqGroup` to one constant pattern, chosen so that whole words and mixed words of group-0 and group-1 lanes both occur. It drives every request for exactly one cycle from the falling edge and leaves an idle cycle after each request.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LANES = 4;
  localparam int PRIO_W = 8;
  localparam int FIRST_SHARED = 32;

  // Strobes from the access control to the priority datapath
  typedef struct packed {
    logic [LANES-1:0] laneWr;   // store the lane's byte this cycle
    logic [LANES-1:0] laneRd;   // return the lane's priority (else zero)
    logic             nsView;   // apply the non-secure scaled view
    logic             rdReq;    // capture read data this cycle
  } prio_strobe_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W = 10
) (
  input  logic                              regValid,
  input  logic                              regWrite,
  input  logic                              regWide,
  input  logic [ADDR_W-1:0]                 regAddr,
  input  logic [31:0]                       regWdata,
  input  logic                              regSecure,
  input  logic [NUM_IRQ-1:0]                irqGroup,
  input  logic                              secOff,
  output prio_strobe_t                      strobe,
  output logic [LANES-1:0][ADDR_W-1:0]      laneIdx,
  output logic [LANES-1:0][PRIO_W-1:0]      laneData
);
  localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(FIRST_SHARED);
  localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(NUM_IRQ);

  logic [ADDR_W-1:0] baseIdx;
  logic [LANES-1:0]  laneUsed;
  logic [LANES-1:0]  laneInRange;
  logic [LANES-1:0]  laneOpen;
  logic              nsView;
  logic              wordFits;

  assign nsView  = !regSecure && !secOff;
  assign baseIdx = regWide ? {regAddr[ADDR_W-1:2], 2'b00} : regAddr;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [NUM_IRQ-1:0] grpShift;
    logic               grpBit;

    assign laneIdx[i]     = baseIdx + ADDR_W'(i);
    assign laneUsed[i]    = (i == 0) || regWide;
    assign laneInRange[i] = (laneIdx[i] >= LO_IDX) && (laneIdx[i] < HI_IDX);
    assign grpShift       = irqGroup >> laneIdx[i];
    assign grpBit         = grpShift[0];
    // group-0 lanes are closed to a non-secure view
    assign laneOpen[i]    = laneUsed[i] && laneInRange[i] && (!nsView || grpBit);
    assign laneData[i]    = regWide ? regWdata[PRIO_W*i +: PRIO_W] : regWdata[PRIO_W-1:0];
  end

  // a word write is dropped whole if any of its lanes lies outside storage
  assign wordFits = laneInRange[0] && laneInRange[LANES-1];

  always_comb begin
    strobe        = '0;
    strobe.nsView = nsView;
    strobe.rdReq  = regValid && !regWrite;
    if (regValid && regWrite && (!regWide || wordFits)) begin
      strobe.laneWr = laneOpen;
    end
    if (regValid && !regWrite) begin
      strobe.laneRd = laneOpen;
    end
  end
endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W = 10
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  prio_strobe_t                   strobe,
  input  logic [LANES-1:0][ADDR_W-1:0]   laneIdx,
  input  logic [LANES-1:0][PRIO_W-1:0]   laneData,
  output logic [31:0]                    rdData,
  output logic                           rdValid,
  output logic [NUM_IRQ*PRIO_W-1:0]      prioArray
);
  localparam int NSHARED = NUM_IRQ - FIRST_SHARED;

  logic [PRIO_W-1:0] prioMem [NSHARED];
  logic [LANES-1:0][PRIO_W-1:0] storeByte;
  logic [LANES-1:0][PRIO_W-1:0] readByte;

  // write-side scaling: the non-secure view can only reach the lower half
  for (genvar i = 0; i < LANES; i++) begin : g_wconv
    assign storeByte[i] = strobe.nsView ? {1'b1, laneData[i][PRIO_W-1:1]} : laneData[i];
  end

  for (genvar j = 0; j < NSHARED; j++) begin : g_entry
    localparam logic [ADDR_W-1:0] MY_IDX = ADDR_W'(j + FIRST_SHARED);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioMem[j] <= '0;
      end else begin
        for (int i = 0; i < LANES; i++) begin
          if (strobe.laneWr[i] && laneIdx[i] == MY_IDX) begin
            prioMem[j] <= storeByte[i];
          end
        end
      end
    end
    assign prioArray[PRIO_W*(j+FIRST_SHARED) +: PRIO_W] = prioMem[j];
  end

  assign prioArray[PRIO_W*FIRST_SHARED-1:0] = '0;

  // read-side lookup and scaling per lane
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [PRIO_W-1:0] raw;
      raw = '0;
      for (int j = 0; j < NSHARED; j++) begin
        if (laneIdx[i] == ADDR_W'(j + FIRST_SHARED)) begin
          raw = prioMem[j];
        end
      end
      if (!strobe.laneRd[i]) begin
        readByte[i] = '0;
      end else if (strobe.nsView) begin
        readByte[i] = {raw[PRIO_W-2:0], 1'b0};
      end else begin
        readByte[i] = raw;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobe.rdReq;
      if (strobe.rdReq) begin
        rdData <= readByte;
      end
    end
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      regValid,
  input  logic                      regWrite,
  input  logic                      regWide,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic [31:0]               regWdata,
  input  logic                      regSecure,
  input  logic [NUM_IRQ-1:0]        irqGroup,
  input  logic                      secOff,
  output logic [31:0]               rdData,
  output logic                      rdValid,
  output logic [NUM_IRQ*8-1:0]      prioArray
);
  prio_strobe_t                 strobe;
  logic [LANES-1:0][ADDR_W-1:0] laneIdx;
  logic [LANES-1:0][PRIO_W-1:0] laneData;

  irq_prio_ctrl #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_ctrl (
    .regValid (regValid),
    .regWrite (regWrite),
    .regWide  (regWide),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regSecure(regSecure),
    .irqGroup (irqGroup),
    .secOff   (secOff),
    .strobe   (strobe),
    .laneIdx  (laneIdx),
    .laneData (laneData)
  );

  irq_prio_store #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .laneIdx  (laneIdx),
    .laneData (laneData),
    .rdData   (rdData),
    .rdValid  (rdValid),
    .prioArray(prioArray)
  );
endmodule

// File: rtl/irq_prio_bank_chk.sv
module irq_prio_bank_chk #(
  parameter int NUM_IRQ = 64,
  parameter int ADDR_W = 10
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regValid,
  input logic                 regWrite,
  input logic                 regWide,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [31:0]          regWdata,
  input logic                 regSecure,
  input logic [NUM_IRQ-1:0]   irqGroup,
  input logic                 secOff,
  input logic [31:0]          rdData,
  input logic                 rdValid,
  input logic [NUM_IRQ*8-1:0] prioArray
);
  localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(NUM_IRQ);

  logic               nsReq;
  logic               byteInRange;
  logic [NUM_IRQ-1:0] grpShift;
  logic               reqGroup;
  logic [ADDR_W-1:0]  lastAddr;
  logic [NUM_IRQ*8-1:0] prioShift;

  assign nsReq       = !regSecure && !secOff;
  assign byteInRange = (regAddr >= ADDR_W'(32)) && (regAddr < HI_IDX);
  assign grpShift    = irqGroup >> regAddr;
  assign reqGroup    = grpShift[0];
  assign prioShift   = prioArray >> {lastAddr, 3'b111};

  always_ff @(posedge clk) lastAddr <= regAddr;

  // R11
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite) |=> rdValid);

  // R11
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && !regWrite) |=> !rdValid);

  // R11
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(regValid && regWrite) |=> $stable(prioArray));

  // R8
  range_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && !regWide && !byteInRange) |=> (rdData == 32'h0));

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && !regWide && nsReq && byteInRange && !reqGroup)
      |=> $stable(prioArray));

  // R6
  ns_read_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && !regWide && nsReq) |=> (rdData[0] == 1'b0));

  // R7
  ns_write_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && !regWide && nsReq && byteInRange && reqGroup)
      |=> prioShift[0]);

  // R3
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && !regWrite && !regWide) |=> (rdData[31:8] == 24'h0));
endmodule

bind irq_prio_bank irq_prio_bank_chk #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_prio_bank_test.sv
module irq_prio_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_IRQ = 62;
  localparam int ADDR_W = 10;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic              wr;
    logic              wide;
    logic              sec;
    logic              dis;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       data;
    logic [31:0]       exp;
    logic [7:0]        req;
  } vec_t;

  localparam int NVEC = 29;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd32, 32'h44332211, 32'h0,        8'd2},
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd32, 32'h0,        32'h44332211, 8'd2},  // R2
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd34, 32'h0,        32'h00000033, 8'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, 10'd32, 32'h0,        32'h0,        8'd5},  // R5
    '{1'b1, 1'b0, 1'b0, 1'b0, 10'd33, 32'hFF,       32'h0,        8'd5},
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd33, 32'h0,        32'h00000022, 8'd5},  // R5
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd36, 32'h804102F3, 32'h0,        8'd6},
    '{1'b0, 1'b1, 1'b0, 1'b0, 10'd36, 32'h0,        32'h008204E6, 8'd6},  // R6
    '{1'b1, 1'b0, 1'b0, 1'b0, 10'd37, 32'h46,       32'h0,        8'd7},
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd37, 32'h0,        32'h000000A3, 8'd7},  // R7
    '{1'b0, 1'b0, 1'b0, 1'b1, 10'd33, 32'h0,        32'h00000022, 8'd4},  // R4
    '{1'b1, 1'b0, 1'b0, 1'b1, 10'd33, 32'h5A,       32'h0,        8'd4},
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd33, 32'h0,        32'h0000005A, 8'd4},  // R4
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd40, 32'h44332211, 32'h0,        8'd10},
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd40, 32'h02020202, 32'h0,        8'd10},
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd40, 32'h0,        32'h44812281, 8'd10}, // R10
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd41, 32'h0,        32'h44812281, 8'd2},  // R2
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd60, 32'hFFFFFF11, 32'h0,        8'd3},
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd61, 32'h22,       32'h0,        8'd9},
    '{1'b1, 1'b1, 1'b1, 1'b0, 10'd60, 32'hAABBCCDD, 32'h0,        8'd9},
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd60, 32'h0,        32'h00002211, 8'd9},  // R9
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd62, 32'h77,       32'h0,        8'd8},
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd62, 32'h0,        32'h0,        8'd8},  // R8
    '{1'b1, 1'b0, 1'b1, 1'b0, 10'd5,  32'h99,       32'h0,        8'd8},
    '{1'b0, 1'b0, 1'b1, 1'b0, 10'd5,  32'h0,        32'h0,        8'd8},  // R8
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd0,  32'h0,        32'h0,        8'd8},  // R8
    '{1'b1, 1'b1, 1'b0, 1'b0, 10'd36, 32'h00000000, 32'h0,        8'd7},
    '{1'b0, 1'b1, 1'b1, 1'b0, 10'd36, 32'h0,        32'h80808080, 8'd7},  // R7
    '{1'b0, 1'b0, 1'b0, 1'b0, 10'd36, 32'h0,        32'h00000000, 8'd6}   // R6
  };

  // irq 36-39,40,42,44-47,52-55,60-61 are group 1
  localparam logic [63:0] GROUP_FULL = {32'hF0F0F5F0, 32'h0};

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 regValid = 1'b0;
  logic                 regWrite = 1'b0;
  logic                 regWide = 1'b0;
  logic [ADDR_W-1:0]    regAddr = '0;
  logic [31:0]          regWdata = '0;
  logic                 regSecure = 1'b0;
  logic [NUM_IRQ-1:0]   irqGroup;
  logic                 secOff = 1'b0;
  logic [31:0]          rdData;
  logic                 rdValid;
  logic [NUM_IRQ*8-1:0] prioArray;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  assign irqGroup = GROUP_FULL[NUM_IRQ-1:0];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_bank #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regWide(regWide), .regAddr(regAddr), .regWdata(regWdata),
    .regSecure(regSecure), .irqGroup(irqGroup), .secOff(secOff),
    .rdData(rdData), .rdValid(rdValid), .prioArray(prioArray)
  );

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one request for one cycle, then idle; returns after the edge that registers it
  task automatic access(input logic wr, input logic wide, input logic sec, input logic dis,
                        input logic [ADDR_W-1:0] addr, input logic [31:0] data);
    @(negedge clk);
    regValid = 1'b1; regWrite = wr; regWide = wide; regSecure = sec;
    secOff = dis; regAddr = addr; regWdata = data;
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0; secOff = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state on the output array and on readback
    check32("R1 prioArray low", prioArray[31:0], 32'h0);
    check32("R1 prioArray shared", {31'h0, |prioArray}, 32'h0);
    access(1'b0, 1'b1, 1'b1, 1'b0, 10'd56, 32'h0);
    check32("R1 readback", rdData, 32'h0);

    for (int v = 0; v < NVEC; v++) begin
      access(VECS[v].wr, VECS[v].wide, VECS[v].sec, VECS[v].dis, VECS[v].addr, VECS[v].data);
      if (!VECS[v].wr) begin
        check32($sformatf("R%0d vector %0d", VECS[v].req, v), rdData, VECS[v].exp);
      end
    end

    // R11: write visible on prioArray one cycle after the request
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regWide = 1'b0; regSecure = 1'b1;
    regAddr = 10'd50; regWdata = 32'h3C;
    check32("R11 before edge", {24'h0, prioArray[50*8 +: 8]}, 32'h0);
    @(negedge clk);
    regValid = 1'b0; regWrite = 1'b0;
    check32("R11 after write", {24'h0, prioArray[50*8 +: 8]}, 32'h3C);
    check32("R11 no rdValid on write", {31'h0, rdValid}, 32'h0);

    // R11: rdValid is a one-cycle pulse aligned with the data
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b0; regWide = 1'b0; regAddr = 10'd50;
    check32("R11 rdValid before", {31'h0, rdValid}, 32'h0);
    @(negedge clk);
    regValid = 1'b0;
    check32("R11 rdValid pulse", {31'h0, rdValid}, 32'h1);
    check32("R11 read data", rdData, 32'h3C);
    @(negedge clk);
    check32("R11 rdValid drop", {31'h0, rdValid}, 32'h0);

    // R7: stored non-secure writes seen directly on the array
    check32("R7 array lanes 36-39", prioArray[36*8 +: 32], 32'h80808080);
    // R9: dropped word write left irq 60/61 as byte writes set them
    check32("R9 array irq 60-61", {16'h0, prioArray[60*8 +: 16]}, 32'h2211);

    done = 1'b1;
    finish_run();
  end
endmodule